// File: doc/BRIEF.md
# SEC-DED RAM Word Decoder

This block checks one 39-bit RAM read word, made of 32 data bits and 7 check bits, and repairs it when exactly one bit has flipped. Six of the check bits form a Hamming code over the data. The seventh check bit holds the parity of the whole word, with odd sense. From these the block computes an 8-bit syndrome. It classifies the word as clean, repaired or beyond repair. It returns the corrected data together with a repaired flag, a non-correctable flag and the index of the flipped bit. A repair may fix a data bit or a check bit.

The decode path is combinational. A parameter `REG_OUT` (default 1) adds one register stage at the outputs. The package also carries an encoder function, which shows how a write path builds the check bits.

Classification is an enumerated decision with five named outcomes:
- `CLS_CLEAN`: no error.
- `CLS_FIX_DATA`: one data bit is in error.
- `CLS_FIX_CHECK`: one Hamming check bit is in error.
- `CLS_FIX_PARITY`: only the overall parity bit is in error.
- `CLS_FATAL`: the word cannot be repaired.

Each output cycle simply reflects the outcome for the word sampled on the previous clock edge. No outcome depends on an earlier one, so there are no transitions between states.

Top module: `secded_word_decoder`

## Requirements
- R1: Codeword layout. Bits [31:0] are data. Bit 32 is the overall parity bit. Bit 32+k (k=1..6) is Hamming bit k. Data bit i has the 6-bit position code c(i): the i-th value, counting from zero, in the ascending list of integers from 3 upward that are not powers of two. Hamming bit k is the XOR of the data bits whose code has bit k-1 set. Bit 32 is chosen so the XOR of all 39 bits is 1.
- R2: Syndrome format. Bit 7 is 0. Bits [6:1] are the XOR of the received Hamming bits with the recomputed ones. Bit 0 is 1 exactly when the XOR of all 39 received bits is 1. A clean word gives syndrome 0x01, data unchanged and neither flag.
- R3: A flip of data bit i gives syndrome {c(i),0}. The output data has that bit restored, `corrected_o` is set and `err_idx_o` equals i.
- R4: A flip of Hamming bit k gives syndrome 1<<k (so 0x02 for k=1 and 0x04 for k=2). The data is unchanged, `corrected_o` is set and `err_idx_o` equals 32+k.
- R5: A flip of the parity bit alone gives syndrome 0x00, with `corrected_o` set and `err_idx_o` equal to 32.
- R6: Two flipped bits give a nonzero position field with bit 0 at 1. This raises `fatal_o` only, passes the received data bits through unmodified and reports `err_idx_o` as 0. A nonzero position field with bit 0 at 0 that matches no bit is also fatal.
- R7: `corrected_o` and `fatal_o` are never high together.
- R8: While the read strobe is low, both flags and `err_idx_o` stay 0. Data and syndrome are still decoded.
- R9: With `REG_OUT`=1, every output reflects the inputs sampled at the previous rising clock edge, and `valid_o` repeats the strobe. An active-low reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid_i | input | 1 | Read word present this cycle |
| codeword_i | input | 39 | Raw word from the RAM |
| data_o | output | 32 | Corrected data |
| syndrome_o | output | 8 | Syndrome (position field and parity bit) |
| corrected_o | output | 1 | One bit was flipped and has been repaired |
| fatal_o | output | 1 | Word is not correctable |
| err_idx_o | output | 6 | Codeword index of the repaired bit |
| valid_o | output | 1 | Outputs belong to a strobed read |

## Verification
A wrong position code or parity term shows up in the very next output cycle as a wrong syndrome value, a missing flag or a bit left unrepaired. A misclassification can make a repairable word look fatal, or the reverse, and it appears at the flags in that same cycle. The decode keeps no history, so every fault is visible one cycle after the word that provokes it. Flipping every single bit of several data patterns therefore exposes each code and each repair path directly.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 32;
    localparam int HAM_W  = 6;
    localparam int CW_W   = DATA_W + HAM_W + 1;
    localparam int SYN_W  = 8;
    localparam int IDX_W  = 6;
    localparam int PAR_AT = DATA_W;

    typedef enum logic [2:0] {
        CLS_CLEAN,
        CLS_FIX_DATA,
        CLS_FIX_CHECK,
        CLS_FIX_PARITY,
        CLS_FATAL
    } cls_e;

    // i-th integer >= 3 that is not a power of two
    function automatic logic [HAM_W-1:0] pos_code(input int idx);
        logic [HAM_W-1:0] res;
        int cnt;
        res = '0;
        cnt = 0;
        for (int v = 3; v < (1 << HAM_W); v++) begin
            if ((v & (v - 1)) != 0) begin
                if (cnt == idx) res = HAM_W'(v);
                cnt++;
            end
        end
        return res;
    endfunction

    function automatic logic [CW_W-1:0] encode(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] w;
        logic [HAM_W-1:0] c;
        w = '0;
        w[DATA_W-1:0] = d;
        for (int k = 0; k < HAM_W; k++) begin
            c = '0;
            for (int i = 0; i < DATA_W; i++) begin
                c = pos_code(i);
                if (c[k]) w[PAR_AT+1+k] = w[PAR_AT+1+k] ^ d[i];
            end
        end
        w[PAR_AT] = ~(^w);
        return w;
    endfunction

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
(
    input  logic [CW_W-1:0]  cw_i,
    output logic [SYN_W-1:0] syn_o
);
    localparam int PAD_W = SYN_W - HAM_W - 1;

    logic [HAM_W-1:0] pos;

    always_comb begin
        pos = cw_i[CW_W-1:PAR_AT+1];
        for (int i = 0; i < DATA_W; i++) begin
            pos = pos ^ ({HAM_W{cw_i[i]}} & pos_code(i));
        end
        syn_o = {{PAD_W{1'b0}}, pos, ^cw_i};
    end
endmodule

// File: rtl/secded_classify.sv
module secded_classify
    import secded_pkg::*;
(
    input  logic [SYN_W-1:0] syn_i,
    output cls_e             cls_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [HAM_W-1:0] pos;
    logic             par_ok;
    logic             hit;

    always_comb begin
        pos    = syn_i[HAM_W:1];
        par_ok = syn_i[0];
        idx_o  = '0;
        hit    = 1'b0;
        cls_o  = CLS_CLEAN;
        if (par_ok) begin
            cls_o = (pos == '0) ? CLS_CLEAN : CLS_FATAL;
        end else if (pos == '0) begin
            cls_o = CLS_FIX_PARITY;
            idx_o = IDX_W'(PAR_AT);
        end else begin
            cls_o = CLS_FATAL;
            for (int k = 0; k < HAM_W; k++) begin
                if (pos == HAM_W'(1 << k)) begin
                    cls_o = CLS_FIX_CHECK;
                    idx_o = IDX_W'(PAR_AT + 1 + k);
                end
            end
            for (int i = 0; i < DATA_W; i++) begin
                if (!hit && pos == pos_code(i)) begin
                    hit   = 1'b1;
                    cls_o = CLS_FIX_DATA;
                    idx_o = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/secded_correct.sv
module secded_correct
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  cls_e              cls_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] data_o
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign data_o[i] = data_i[i] ^ ((cls_i == CLS_FIX_DATA) && (idx_i == IDX_W'(i)));
    end
endmodule

// File: rtl/secded_word_decoder.sv
module secded_word_decoder
    import secded_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid_i,
    input  logic [CW_W-1:0]   codeword_i,
    output logic [DATA_W-1:0] data_o,
    output logic [SYN_W-1:0]  syndrome_o,
    output logic              corrected_o,
    output logic              fatal_o,
    output logic [IDX_W-1:0]  err_idx_o,
    output logic              valid_o
);
    logic [SYN_W-1:0]  syn;
    cls_e              cls;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] fixed;
    logic              fix_n;
    logic              bad_n;
    logic [IDX_W-1:0]  idx_n;

    secded_syndrome u_syn (
        .cw_i  (codeword_i),
        .syn_o (syn)
    );

    secded_classify u_cls (
        .syn_i (syn),
        .cls_o (cls),
        .idx_o (idx)
    );

    secded_correct u_fix (
        .data_i (codeword_i[DATA_W-1:0]),
        .cls_i  (cls),
        .idx_i  (idx),
        .data_o (fixed)
    );

    // outcome decode
    always_comb begin
        fix_n = 1'b0;
        bad_n = 1'b0;
        unique case (cls)
            CLS_CLEAN:                                   ;
            CLS_FIX_DATA, CLS_FIX_CHECK, CLS_FIX_PARITY: fix_n = rd_valid_i;
            CLS_FATAL:                                   bad_n = rd_valid_i;
            default:                                     ;
        endcase
        idx_n = fix_n ? idx : '0;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_o      <= '0;
                syndrome_o  <= '0;
                corrected_o <= 1'b0;
                fatal_o     <= 1'b0;
                err_idx_o   <= '0;
                valid_o     <= 1'b0;
            end else begin
                data_o      <= fixed;
                syndrome_o  <= syn;
                corrected_o <= fix_n;
                fatal_o     <= bad_n;
                err_idx_o   <= idx_n;
                valid_o     <= rd_valid_i;
            end
        end
    end else begin : g_comb
        assign data_o      = fixed;
        assign syndrome_o  = syn;
        assign corrected_o = fix_n;
        assign fatal_o     = bad_n;
        assign err_idx_o   = idx_n;
        assign valid_o     = rd_valid_i;
    end
endmodule

// File: rtl/secded_word_decoder_chk.sv
module secded_word_decoder_chk
    import secded_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SYN_W-1:0] syndrome_o,
    input logic             corrected_o,
    input logic             fatal_o,
    input logic [IDX_W-1:0] err_idx_o,
    input logic             valid_o
);
    // R7
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(corrected_o && fatal_o));

    // R8
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!corrected_o && !fatal_o && err_idx_o == '0));

    // R2
    clean_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && syndrome_o == 8'h01) |-> (!corrected_o && !fatal_o));

    // R5
    parity_only_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && syndrome_o == 8'h00) |-> (corrected_o && err_idx_o == IDX_W'(PAR_AT)));

    // R6
    fatal_has_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |-> (syndrome_o[HAM_W:1] != '0));

    // R3
    data_fix_bad_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corrected_o && err_idx_o < IDX_W'(DATA_W)) |-> !syndrome_o[0]);
endmodule

bind secded_word_decoder secded_word_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .syndrome_o  (syndrome_o),
    .corrected_o (corrected_o),
    .fatal_o     (fatal_o),
    .err_idx_o   (err_idx_o),
    .valid_o     (valid_o)
);

// File: tb/tb_secded_word_decoder.sv
module tb_secded_word_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [38:0] cw = '0;
    logic [31:0] data_o;
    logic [7:0]  syndrome_o;
    logic        corrected_o, fatal_o, valid_o;
    logic [5:0]  err_idx_o;

    secded_word_decoder dut (
        .clk(clk), .rst_n(rst_n), .rd_valid_i(rd_valid), .codeword_i(cw),
        .data_o(data_o), .syndrome_o(syndrome_o), .corrected_o(corrected_o),
        .fatal_o(fatal_o), .err_idx_o(err_idx_o), .valid_o(valid_o)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit pend = 0;
    string e_req;
    logic [31:0] e_data;
    logic [7:0]  e_syn;
    logic        e_c, e_f, e_v;
    logic [5:0]  e_idx;

    function automatic int bcode(int i);
        int cnt = 0;
        int r = 0;
        for (int v = 3; v < 64; v++) begin
            if ((v & (v - 1)) != 0) begin
                if (cnt == i) r = v;
                cnt++;
            end
        end
        return r;
    endfunction

    // code contribution of codeword bit p (R1)
    function automatic int pcode(int p);
        if (p < 32) return bcode(p);
        if (p == 32) return 0;
        return 1 << (p - 33);
    endfunction

    function automatic logic [38:0] benc(logic [31:0] d);
        logic [38:0] w = '0;
        w[31:0] = d;
        for (int k = 1; k <= 6; k++)
            for (int i = 0; i < 32; i++)
                if (((bcode(i) >> (k - 1)) & 1) == 1) w[32 + k] = w[32 + k] ^ d[i];
        w[32] = 1'b1 ^ (^w);
        return w;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        if (pend) begin
            chk(e_req, "data", 64'(data_o), 64'(e_data));
            chk(e_req, "syndrome", 64'(syndrome_o), 64'(e_syn));
            chk(e_req, "corrected", 64'(corrected_o), 64'(e_c));
            chk(e_req, "fatal", 64'(fatal_o), 64'(e_f));
            chk(e_req, "index", 64'(err_idx_o), 64'(e_idx));
            chk("R9", "valid", 64'(valid_o), 64'(e_v));
            chk("R7", "exclusive", 64'(corrected_o && fatal_o), 64'(0));
        end
    endtask

    task automatic drive(logic [31:0] d, int p1, int p2, logic v, string req);
        logic [38:0] raw;
        @(negedge clk);
        compare();
        raw = benc(d);
        if (p1 >= 0) raw[p1] = ~raw[p1];
        if (p2 >= 0) raw[p2] = ~raw[p2];
        e_data = d; e_c = 0; e_f = 0; e_idx = 0; e_v = v; e_req = req;
        if (p1 < 0) begin
            e_syn = 8'h01;
        end else if (p2 < 0) begin
            e_syn = 8'(pcode(p1) << 1);
            e_c = v;
            e_idx = v ? 6'(p1) : 6'd0;
        end else begin
            e_syn = 8'(((pcode(p1) ^ pcode(p2)) << 1) | 1);
            e_f = v;
            e_data = raw[31:0];
        end
        cw = raw;
        rd_valid = v;
        pend = 1;
    endtask

    initial begin
        #(64'd8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5A5_3C96; pats[3] = 32'h1234_5678;
        cw = 39'h7F_FFFF_FFFF; rd_valid = 1'b1;
        @(negedge clk); @(negedge clk);
        // R9: reset state
        chk("R9", "reset data", 64'(data_o), 0);
        chk("R9", "reset syndrome", 64'(syndrome_o), 0);
        chk("R9", "reset flags", 64'({corrected_o, fatal_o, valid_o}), 0);
        chk("R9", "reset index", 64'(err_idx_o), 0);
        rst_n = 1'b1;
        for (int q = 0; q < 4; q++) begin
            drive(pats[q], -1, -1, 1, "R2");
            for (int p = 0; p < 39; p++) begin
                if (p < 32)       drive(pats[q], p, -1, 1, "R3");
                else if (p == 32) drive(pats[q], p, -1, 1, "R5");
                else              drive(pats[q], p, -1, 1, "R4");
            end
            for (int p = 0; p < 39; p++) begin
                drive(pats[q], p, (p + 13) % 39, 1, "R6");
                drive(pats[q], p, (p + 1) % 39, 1, "R6");
            end
            // R8: strobe low with a flip present, flags stay low
            drive(pats[q], 5 + q, -1, 0, "R8");
            drive(pats[q], 3, 20, 0, "R8");
            drive(pats[q], 34, -1, 1, "R1");
        end
        @(negedge clk);
        compare();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule